// File: doc/BRIEF.md
# Register File with Post-Increment Move

This block holds a small bank of general registers and executes one register-to-register instruction per clock edge. Four operations exist: do nothing, copy one register into another, add one to a register in place, and a combined copy-then-bump that in a single edge loads the target with the source's old value while writing the source back as its old value plus one.

The post-increment move opens two write paths at once: a copy path aimed at the target and an increment path aimed at the source. Nothing checks whether both name the same register. When they do, the instruction still executes and does not trap. Each register collects every path that targets it in that cycle and stores the bitwise AND of their values, much like an open-drain node where a low bit always wins. A register that is targeted by one path only takes that path's value unchanged.

Instructions enter on a valid/ready pair. `in_ready` is low only while reset is asserted; otherwise the block accepts one instruction on every edge and never applies back-pressure. An instruction takes effect on an edge where both `in_valid` and `in_ready` are high, and the result shows on the debug read bus right after that edge. Every register is visible at all times on that flat bus.

Top module: `rfpi_core`

## Requirements
- R1: With `rst` high at an edge, all registers become 8'h00 after that edge, whatever instruction is presented in the same cycle.
- R2: Opcode 2'b01 (move) writes the source register's value into the target register. The source keeps its value.
- R3: Opcode 2'b10 (increment) writes source+1 back into the source register, modulo 256, so 8'hFF becomes 8'h00.
- R4: Opcode 2'b11 (post-increment move) with distinct indices writes the old source value into the target and old source+1 into the source, both on the same edge.
- R5: Opcode 2'b11 with source equal to target stores the old value ANDed with the old value plus one (mod 256). For example 5 becomes 4 and 8'hFF becomes 8'h00. The instruction executes normally.
- R6: With `in_valid` low, or with opcode 2'b00, no register changes.
- R7: Registers not named by an executed instruction keep their value.
- R8: `in_ready` is low while `rst` is high and high otherwise. An instruction is accepted on an edge only when `in_valid` and `in_ready` are both high.
- R9: Register k appears on `dbg_regs[8k+7:8k]`, with register 0 in the lowest byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Block accepts an instruction this cycle |
| in_op | input | 2 | Opcode: 00 nop, 01 move, 10 increment, 11 post-increment move |
| in_src | input | 3 | Source register index |
| in_dst | input | 3 | Target register index |
| dbg_regs | output | 64 | All registers, register k in byte k |

## Verification
The copy path and the increment path of the post-increment move can both land on one register in the same cycle. The bench provokes this by issuing opcode 2'b11 with equal indices on registers loaded with 5 and with 8'hFF. It judges the result against a model that ANDs both drivers, expecting 4 and 0, and checks that the other registers are untouched. The other collision is reset meeting an instruction on the same edge. It is provoked by holding a valid post-increment move while reset is high, and it is judged by all registers reading zero.

// File: rtl/rfpi_pkg.sv
package rfpi_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'b00,
    OP_MOV = 2'b01,
    OP_INC = 2'b10,
    OP_MPI = 2'b11
  } rfpi_op_e;
endpackage

// File: rtl/rfpi_route.sv
module rfpi_route
  import rfpi_pkg::*;
#(
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input  logic            fire,
  input  logic [1:0]      op,
  input  logic [IDXW-1:0] src,
  input  logic [IDXW-1:0] dst,
  input  logic [W-1:0]    src_val,
  output logic            cp_en,
  output logic [IDXW-1:0] cp_idx,
  output logic [W-1:0]    cp_dat,
  output logic            up_en,
  output logic [IDXW-1:0] up_idx,
  output logic [W-1:0]    up_dat
);
  rfpi_op_e opc;
  assign opc = rfpi_op_e'(op);

  // copy path: source value toward the target
  always_comb begin
    cp_en  = fire && (opc == OP_MOV || opc == OP_MPI);
    cp_idx = dst;
    cp_dat = src_val;
  end

  // increment path: source+1 back toward the source (wraps)
  always_comb begin
    up_en  = fire && (opc == OP_INC || opc == OP_MPI);
    up_idx = src;
    up_dat = src_val + W'(1);
  end
endmodule

// File: rtl/rfpi_merge.sv
module rfpi_merge #(
  parameter int NREG = 8,
  parameter int W    = 8,
  parameter int IDXW = 3
) (
  input  logic            cp_en,
  input  logic [IDXW-1:0] cp_idx,
  input  logic [W-1:0]    cp_dat,
  input  logic            up_en,
  input  logic [IDXW-1:0] up_idx,
  input  logic [W-1:0]    up_dat,
  output logic [NREG-1:0] we,
  output logic [W-1:0]    wd [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_node
    logic hit_cp, hit_up;
    assign hit_cp = cp_en && (cp_idx == IDXW'(i));
    assign hit_up = up_en && (up_idx == IDXW'(i));
    assign we[i]  = hit_cp | hit_up;
    // wired-AND: an absent driver contributes all ones
    assign wd[i]  = (hit_cp ? cp_dat : {W{1'b1}}) & (hit_up ? up_dat : {W{1'b1}});
  end
endmodule

// File: rtl/rfpi_bank.sv
module rfpi_bank #(
  parameter int NREG = 8,
  parameter int W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] we,
  input  logic [W-1:0]    wd [NREG],
  output logic [W-1:0]    q  [NREG]
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (we[i]) q[i] <= wd[i];
    end

    p_reset_clear_r1: assert property (@(posedge clk) rst |=> (q[i] == '0))
      else $error("register %0d not cleared by reset", i);

    p_hold_unwritten_r7: assert property (@(posedge clk) disable iff (rst)
      !we[i] |=> $stable(q[i]))
      else $error("register %0d changed without a write", i);
  end
endmodule

// File: rtl/rfpi_core.sv
module rfpi_core
  import rfpi_pkg::*;
#(
  parameter int NREG = 8,
  parameter int W    = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_op,
  input  logic [IDXW-1:0]   in_src,
  input  logic [IDXW-1:0]   in_dst,
  output logic [NREG*W-1:0] dbg_regs
);
  logic            fire;
  logic [W-1:0]    q  [NREG];
  logic [W-1:0]    wd [NREG];
  logic [NREG-1:0] we;
  logic [W-1:0]    src_val;
  logic            cp_en, up_en;
  logic [IDXW-1:0] cp_idx, up_idx;
  logic [W-1:0]    cp_dat, up_dat;

  assign in_ready = !rst;
  assign fire     = in_valid && in_ready;
  assign src_val  = q[in_src];

  rfpi_route #(.W(W), .IDXW(IDXW)) u_route (
    .fire(fire), .op(in_op), .src(in_src), .dst(in_dst), .src_val(src_val),
    .cp_en(cp_en), .cp_idx(cp_idx), .cp_dat(cp_dat),
    .up_en(up_en), .up_idx(up_idx), .up_dat(up_dat)
  );

  rfpi_merge #(.NREG(NREG), .W(W), .IDXW(IDXW)) u_merge (
    .cp_en(cp_en), .cp_idx(cp_idx), .cp_dat(cp_dat),
    .up_en(up_en), .up_idx(up_idx), .up_dat(up_dat),
    .we(we), .wd(wd)
  );

  rfpi_bank #(.NREG(NREG), .W(W)) u_bank (
    .clk(clk), .rst(rst), .we(we), .wd(wd), .q(q)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_dbg
    assign dbg_regs[k*W +: W] = q[k];
  end

  p_ready_follows_reset_r8: assert property (@(posedge clk) in_ready == !rst)
    else $error("ready does not track reset");

  p_mov_copy_r2: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 2'b01) |=> (q[$past(in_dst)] == $past(src_val)))
    else $error("move did not copy source");

  p_inc_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 2'b10) |=> (q[$past(in_src)] == W'($past(src_val) + W'(1))))
    else $error("increment wrong");

  p_mpi_split_r4: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 2'b11 && in_src != in_dst) |=>
      (q[$past(in_dst)] == $past(src_val)) &&
      (q[$past(in_src)] == W'($past(src_val) + W'(1))))
    else $error("post-increment move wrong");

  p_mpi_same_and_r5: assert property (@(posedge clk) disable iff (rst)
    (fire && in_op == 2'b11 && in_src == in_dst) |=>
      (q[$past(in_src)] == ($past(src_val) & W'($past(src_val) + W'(1)))))
    else $error("same-register post-increment not wired-AND");

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_op == 2'b00) |=> $stable(dbg_regs))
    else $error("registers changed while idle");
endmodule

// File: tb/rfpi_core_bench.sv
module rfpi_core_bench;
  localparam int NREG = 8;
  localparam int W    = 8;

  typedef struct {
    logic [NREG*W-1:0] regs;
    string             tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_op = 2'b00;
  logic [2:0] in_src = '0, in_dst = '0;
  logic [NREG*W-1:0] dbg_regs;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  exp_t q_exp[$];
  logic [W-1:0] m [NREG];

  always #5 clk = ~clk;

  rfpi_core #(.NREG(NREG), .W(W)) u_rfpi_core (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_src(in_src), .in_dst(in_dst), .dbg_regs(dbg_regs)
  );

  function automatic logic [NREG*W-1:0] pack_model();
    logic [NREG*W-1:0] v;
    for (int k = 0; k < NREG; k++) v[k*W +: W] = m[k];
    return v;
  endfunction

  // driver: present one instruction, update model, queue expectation
  task automatic issue(input bit r, input bit v, input logic [1:0] op,
                       input int s, input int d, input string tag);
    exp_t e;
    logic [W-1:0] sv;
    logic [W-1:0] nxt [NREG];
    logic [NREG-1:0] hit;
    @(negedge clk);
    rst = r; in_valid = v; in_op = op; in_src = 3'(s); in_dst = 3'(d);
    sv = m[s];
    for (int k = 0; k < NREG; k++) begin nxt[k] = '1; hit[k] = 1'b0; end
    if (!r && v) begin
      if (op == 2'b01 || op == 2'b11) begin nxt[d] &= sv; hit[d] = 1'b1; end
      if (op == 2'b10 || op == 2'b11) begin nxt[s] &= sv + 8'd1; hit[s] = 1'b1; end
    end
    for (int k = 0; k < NREG; k++)
      m[k] = r ? 8'h00 : (hit[k] ? nxt[k] : m[k]);
    e.regs = pack_model();
    e.tag  = tag;
    q_exp.push_back(e);
  endtask

  // monitor: after each edge, compare against the oldest expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_exp.size() > 0) begin
        exp_t e;
        e = q_exp.pop_front();
        n_vec++;
        if (dbg_regs !== e.regs) begin
          n_bad++;
          $display("FAIL %s: regs=%h expected=%h", e.tag, dbg_regs, e.regs);
        end
      end
    end
  end

  task automatic check_ready(input logic exp, input string tag);
    n_vec++;
    if (in_ready !== exp) begin
      n_bad++;
      $display("FAIL %s: in_ready=%b expected=%b", tag, in_ready, exp);
    end
  endtask

  task automatic load(input int idx, input int val);
    for (int i = 0; i < val; i++) issue(0, 1, 2'b10, idx, 0, "R3 load");
  endtask

  initial begin
    for (int k = 0; k < NREG; k++) m[k] = 8'hxx;
    issue(1, 0, 2'b00, 0, 0, "R1 reset clear");
    @(negedge clk); #1 check_ready(1'b0, "R8 ready low in reset");
    issue(0, 0, 2'b00, 0, 0, "R6 idle after reset");
    #1 check_ready(1'b1, "R8 ready high");
    load(1, 5);
    issue(0, 1, 2'b01, 1, 2, "R2 move r1->r2");
    issue(0, 1, 2'b11, 1, 3, "R4 mpi r1->r3");
    issue(0, 1, 2'b11, 3, 3, "R5 mpi same 5->4");
    load(4, 255);
    issue(0, 1, 2'b10, 4, 0, "R3 increment wrap FF->00");
    load(5, 255);
    issue(0, 1, 2'b11, 5, 5, "R5 mpi same FF->00");
    load(6, 3);
    issue(0, 1, 2'b11, 6, 6, "R5 mpi same 3->0");
    issue(0, 0, 2'b11, 1, 2, "R6 valid low ignored");
    issue(0, 1, 2'b00, 1, 2, "R6 nop ignored");
    issue(0, 1, 2'b11, 2, 7, "R4 mpi r2->r7 R7 others hold");
    issue(0, 1, 2'b01, 7, 0, "R9 move into byte 0");
    issue(1, 1, 2'b11, 1, 1, "R1 reset beats instruction");
    issue(0, 1, 2'b10, 0, 0, "R8 accepted after reset");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: expired, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule